// File: doc/BRIEF.md
# Serial Status Flag Register

This block is the status register of an asynchronous serial controller. It holds five sticky event flags: transmit buffer empty, receive buffer full, overrun, parity error and framing error. It also shows two read-only bits that mirror the transmitter's end-of-transmission state and the received multiprocessor bit. Pulses from the transmitter and the receiver set the flags. Software can only clear a flag, and only in two steps: it reads the flag while it is 1, then writes a 0 to that bit position. Writing 1 never sets anything. A 0 written without a qualifying earlier read is dropped. This stops a read-modify-write from wiping out an event that arrived after the read.

The block also decides whether a finished character may enter the receive data buffer. While the receive-full flag is still set, a newly completed character raises overrun and is discarded. Its buffer-load strobe stays low, so the held character survives.

Top module: `serial_status_reg`

## Requirements
- R1: After reset the flags are: transmit-empty 1, all other flags 0. With the transmit-end and multiprocessor inputs low, the status reads 0x80.
- R2: Status bit positions are: bit 7 transmit-empty, bit 6 receive-full, bit 5 overrun, bit 4 parity error, bit 3 framing error. Bit 2 mirrors `tx_end_i`, bit 1 mirrors `mpb_i`, and bit 0 always reads 0.
- R3: A CPU write with a 1 in any flag position never sets that flag.
- R4: A write of 0 to a flag that was not read as 1 since the last write leaves the flag unchanged.
- R5: A read that returns 1 for a flag, followed by a write with 0 in that position, clears the flag from the next cycle on. Flags written with 1 in the same write are untouched.
- R6: Transmit-empty is set by a buffer-to-shifter load pulse, by transmit enable being low, and by standby.
- R7: A completed character with receive enabled and receive-full at 0 sets receive-full. `rx_buf_load_o` pulses in that same cycle.
- R8: A completed character while receive-full is 1 sets overrun. `rx_buf_load_o` stays low and receive-full stays 1.
- R9: Parity and framing errors, and receive enable going low, leave receive-full unchanged. A completed character while receive enable is low has no effect.
- R10: Standby clears receive-full and sets transmit-empty.
- R11: If a hardware set and a qualifying CPU clear hit the same flag in the same cycle, the flag stays 1. A later write of 0 without a new read does not clear it.
- R12: Any CPU write disarms every flag. A read-1, then a write-1, then a write-0 leaves the flag set.
- R13: A parity error pulse sets the parity flag and a framing error pulse sets the framing flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rd_i | input | 1 | CPU read strobe for the status register |
| wr_i | input | 1 | CPU write strobe for the status register |
| wr_data_i | input | 8 | CPU write data |
| status_o | output | 8 | Status value, combinational from the flags |
| tx_en_i | input | 1 | Transmit enable level |
| rx_en_i | input | 1 | Receive enable level |
| standby_i | input | 1 | Standby request level |
| tx_load_i | input | 1 | Pulse: transmit buffer moved into the shifter |
| rx_done_i | input | 1 | Pulse: receive shifter holds a finished character |
| par_err_i | input | 1 | Pulse: parity error detected |
| frm_err_i | input | 1 | Pulse: framing error detected |
| tx_end_i | input | 1 | Transmitter idle after the last bit |
| mpb_i | input | 1 | Multiprocessor bit of the last received character |
| rx_buf_load_o | output | 1 | Pulse: copy the shifter into the receive buffer |

## Verification
The bench builds the block with its default flag reset pattern: transmit-empty set, every other flag clear. The R1 check therefore expects exactly 0x80. Because register width and flag positions are fixed by the package, this single build reaches every flag cell and every event path. The tests use one-cycle pulses, so they can stage the corner cases directly: a set and a clear in the same cycle, two receptions in a row, and a write of 1 placed between a read and a clear.

// File: rtl/ssr_pkg.sv
package ssr_pkg;
  localparam int REG_W     = 8;
  localparam int NUM_FLAGS = 5;
  localparam int FLAG_LSB  = REG_W - NUM_FLAGS;

  // flag index inside the flag vector; status bit = FLAG_LSB + index
  localparam int F_FER  = 0;
  localparam int F_PER  = 1;
  localparam int F_ORER = 2;
  localparam int F_RDRF = 3;
  localparam int F_TDRE = 4;

  function automatic logic flag_next(logic cur, logic hw_set, logic hw_clr, logic cpu_clr);
    if (hw_set)                return 1'b1;
    else if (hw_clr || cpu_clr) return 1'b0;
    else                        return cur;
  endfunction

  function automatic logic armed_next(logic cur, logic flag, logic rd, logic wr);
    if (wr)             return 1'b0;
    else if (rd && flag) return 1'b1;
    else                return cur & flag;
  endfunction

  function automatic logic [REG_W-1:0] compose_status(logic [NUM_FLAGS-1:0] flags,
                                                      logic tend, logic mpb);
    return {flags, tend, mpb, 1'b0};
  endfunction
endpackage

// File: rtl/ssr_event_qual.sv
module ssr_event_qual
  import ssr_pkg::*;
(
  input  logic                 tx_en_i,
  input  logic                 rx_en_i,
  input  logic                 standby_i,
  input  logic                 tx_load_i,
  input  logic                 rx_done_i,
  input  logic                 par_err_i,
  input  logic                 frm_err_i,
  input  logic                 rdrf_q_i,
  output logic [NUM_FLAGS-1:0] hw_set_o,
  output logic [NUM_FLAGS-1:0] hw_clr_o,
  output logic                 rx_accept_o
);
  logic rx_valid;

  assign rx_valid    = rx_done_i & rx_en_i & ~standby_i;
  assign rx_accept_o = rx_valid & ~rdrf_q_i;

  always_comb begin
    hw_set_o         = '0;
    hw_clr_o         = '0;
    hw_set_o[F_TDRE] = tx_load_i | ~tx_en_i | standby_i;
    hw_set_o[F_RDRF] = rx_accept_o;
    hw_set_o[F_ORER] = rx_valid & rdrf_q_i;
    hw_set_o[F_PER]  = par_err_i;
    hw_set_o[F_FER]  = frm_err_i;
    hw_clr_o[F_RDRF] = standby_i;
  end
endmodule

// File: rtl/ssr_flag_cell.sv
module ssr_flag_cell
  import ssr_pkg::*;
#(
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hw_set_i,
  input  logic hw_clr_i,
  input  logic rd_i,
  input  logic wr_i,
  input  logic wr_bit_i,
  output logic flag_o,
  output logic armed_o
);
  logic cpu_clr;

  assign cpu_clr = wr_i & armed_o & ~wr_bit_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_o  <= RST_VAL;
      armed_o <= 1'b0;
    end else begin
      flag_o  <= flag_next(flag_o, hw_set_i, hw_clr_i, cpu_clr);
      armed_o <= armed_next(armed_o, flag_o, rd_i, wr_i);
    end
  end
endmodule

// File: rtl/serial_status_reg.sv
module serial_status_reg
  import ssr_pkg::*;
#(
  parameter logic [NUM_FLAGS-1:0] FLAG_RESET = 5'b10000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rd_i,
  input  logic             wr_i,
  input  logic [REG_W-1:0] wr_data_i,
  output logic [REG_W-1:0] status_o,
  input  logic             tx_en_i,
  input  logic             rx_en_i,
  input  logic             standby_i,
  input  logic             tx_load_i,
  input  logic             rx_done_i,
  input  logic             par_err_i,
  input  logic             frm_err_i,
  input  logic             tx_end_i,
  input  logic             mpb_i,
  output logic             rx_buf_load_o
);
  logic [NUM_FLAGS-1:0] flags;
  logic [NUM_FLAGS-1:0] armed;
  logic [NUM_FLAGS-1:0] hw_set;
  logic [NUM_FLAGS-1:0] hw_clr;
  logic                 rx_accept;

  ssr_event_qual u_qual (
    .tx_en_i    (tx_en_i),
    .rx_en_i    (rx_en_i),
    .standby_i  (standby_i),
    .tx_load_i  (tx_load_i),
    .rx_done_i  (rx_done_i),
    .par_err_i  (par_err_i),
    .frm_err_i  (frm_err_i),
    .rdrf_q_i   (flags[F_RDRF]),
    .hw_set_o   (hw_set),
    .hw_clr_o   (hw_clr),
    .rx_accept_o(rx_accept)
  );

  for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_flag
    ssr_flag_cell #(.RST_VAL(FLAG_RESET[i])) u_cell (
      .clk     (clk),
      .rst_n   (rst_n),
      .hw_set_i(hw_set[i]),
      .hw_clr_i(hw_clr[i]),
      .rd_i    (rd_i),
      .wr_i    (wr_i),
      .wr_bit_i(wr_data_i[FLAG_LSB+i]),
      .flag_o  (flags[i]),
      .armed_o (armed[i])
    );
  end

  assign status_o      = compose_status(flags, tx_end_i, mpb_i);
  assign rx_buf_load_o = rx_accept;
endmodule

// File: rtl/ssr_checker.sv
module ssr_checker
  import ssr_pkg::*;
(
  input logic                 clk,
  input logic                 rst_n,
  input logic                 wr_i,
  input logic [REG_W-1:0]     wr_data_i,
  input logic [REG_W-1:0]     status_o,
  input logic                 tx_en_i,
  input logic                 standby_i,
  input logic                 rx_buf_load_o,
  input logic [NUM_FLAGS-1:0] hw_set,
  input logic [NUM_FLAGS-1:0] armed
);
  localparam int B_RDRF = FLAG_LSB + F_RDRF;
  localparam int B_TDRE = FLAG_LSB + F_TDRE;
  localparam int B_ORER = FLAG_LSB + F_ORER;

  AST_RDRF_RISE_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status_o[B_RDRF]) |-> $past(hw_set[F_RDRF])); // R7
  AST_ORER_RISE_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status_o[B_ORER]) |-> $past(hw_set[F_ORER])); // R8
  AST_NO_LOAD_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    rx_buf_load_o |-> !status_o[B_RDRF]); // R8
  AST_RDRF_FALL_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(status_o[B_RDRF]) |-> ($past(standby_i) ||
      ($past(wr_i) && $past(armed[F_RDRF]) && !$past(wr_data_i[B_RDRF])))); // R4
  AST_TDRE_TE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_en_i |=> status_o[B_TDRE]); // R6
  AST_STANDBY_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    standby_i |=> !status_o[B_RDRF]); // R10
  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    hw_set[F_TDRE] |=> status_o[B_TDRE]); // R11
  AST_WRITE_DISARMS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_i |=> armed == '0); // R12
endmodule

bind serial_status_reg ssr_checker u_ssr_checker (
  .clk          (clk),
  .rst_n        (rst_n),
  .wr_i         (wr_i),
  .wr_data_i    (wr_data_i),
  .status_o     (status_o),
  .tx_en_i      (tx_en_i),
  .standby_i    (standby_i),
  .rx_buf_load_o(rx_buf_load_o),
  .hw_set       (hw_set),
  .armed        (armed)
);

// File: tb/tb_serial_status_reg.sv
module tb_serial_status_reg;
  logic       clk = 0;
  logic       rst_n = 0;
  logic       rd = 0, wr = 0;
  logic [7:0] wdata = 0;
  logic [7:0] status;
  logic       te = 0, re = 0, stby = 0, txld = 0, rxd = 0, perr = 0, ferr = 0;
  logic       tend = 0, mpb = 0;
  logic       rxload;
  int         checks = 0, fails = 0;

  always #10 clk = ~clk;

  serial_status_reg dut (
    .clk(clk), .rst_n(rst_n), .rd_i(rd), .wr_i(wr), .wr_data_i(wdata),
    .status_o(status), .tx_en_i(te), .rx_en_i(re), .standby_i(stby),
    .tx_load_i(txld), .rx_done_i(rxd), .par_err_i(perr), .frm_err_i(ferr),
    .tx_end_i(tend), .mpb_i(mpb), .rx_buf_load_o(rxload)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cpu_read(output logic [7:0] v);
    @(negedge clk); rd = 1; #1 v = status;
    @(negedge clk); rd = 0;
  endtask

  task automatic cpu_write(input logic [7:0] d);
    @(negedge clk); wr = 1; wdata = d;
    @(negedge clk); wr = 0; wdata = 0;
  endtask

  task automatic rx_char(output logic load);
    @(negedge clk); rxd = 1; #1 load = rxload;
    @(negedge clk); rxd = 0;
  endtask

  task automatic clear_bits(input logic [7:0] zero_mask);
    logic [7:0] v;
    cpu_read(v);
    cpu_write(~zero_mask);
  endtask

  task automatic t_reset;
    #1 chk("R1 reset value", status, 8'h80);
    @(negedge clk); te = 1; re = 1;
  endtask

  task automatic t_layout;
    @(negedge clk); tend = 1; mpb = 0; #1 chk("R2 tend bit2", status & 8'h07, 8'h04);
    mpb = 1; tend = 0; #1 chk("R2 mpb bit1 bit0 zero", status & 8'h07, 8'h02);
    mpb = 0;
  endtask

  task automatic t_write_rules;
    cpu_write(8'hFF);
    chk("R3 write ones ignored", status, 8'h80);
    cpu_write(8'h00);
    chk("R4 write zero without read", status, 8'h80);
    clear_bits(8'h80);
    chk("R5 read then write zero clears", status, 8'h00);
  endtask

  task automatic t_tdre_sources;
    @(negedge clk); txld = 1; @(negedge clk); txld = 0;
    chk("R6 tx load sets empty", status & 8'h80, 8'h80);
    clear_bits(8'h80);
    @(negedge clk); te = 0; @(negedge clk); te = 1;
    chk("R6 te low sets empty", status & 8'h80, 8'h80);
    clear_bits(8'h80);
    @(negedge clk); stby = 1; @(negedge clk); stby = 0;
    chk("R6 standby sets empty", status & 8'h80, 8'h80);
    clear_bits(8'h80);
  endtask

  task automatic t_receive;
    logic ld;
    rx_char(ld);
    chk("R7 load strobe", {7'b0, ld}, 8'h01);
    chk("R7 full set", status & 8'hF8, 8'h40);
    rx_char(ld);
    chk("R8 no load on overrun", {7'b0, ld}, 8'h00);
    chk("R8 overrun set full kept", status & 8'hF8, 8'h60);
    @(negedge clk); perr = 1; @(negedge clk); perr = 0;
    chk("R13 parity flag", status & 8'h10, 8'h10);
    @(negedge clk); ferr = 1; @(negedge clk); ferr = 0;
    chk("R13 framing flag", status & 8'h08, 8'h08);
    chk("R9 errors keep full", status & 8'h40, 8'h40);
    @(negedge clk); re = 0;
    @(negedge clk);
    chk("R9 re low keeps full", status & 8'h40, 8'h40);
    clear_bits(8'h40);
    rx_char(ld);
    chk("R9 rx ignored when disabled", {status & 8'h40, ld}, 8'h00);
    @(negedge clk); re = 1;
    chk("R5 other flags untouched", status & 8'h38, 8'h38);
    clear_bits(8'h38);
    chk("R5 multi clear", status, 8'h00);
  endtask

  task automatic t_standby;
    logic ld;
    rx_char(ld);
    @(negedge clk); stby = 1; @(negedge clk); stby = 0;
    chk("R10 standby empties rx sets tx", status & 8'hC0, 8'h80);
    clear_bits(8'h80);
  endtask

  task automatic t_set_wins;
    logic [7:0] v;
    @(negedge clk); txld = 1; @(negedge clk); txld = 0;
    cpu_read(v);
    @(negedge clk); wr = 1; wdata = 8'h7F; txld = 1;
    @(negedge clk); wr = 0; wdata = 0; txld = 0;
    chk("R11 set beats clear", status & 8'h80, 8'h80);
    cpu_write(8'h7F);
    chk("R11 disarmed after collision", status & 8'h80, 8'h80);
    cpu_read(v);
    cpu_write(8'hFF);
    cpu_write(8'h7F);
    chk("R12 write disarms", status & 8'h80, 8'h80);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    t_layout();
    t_write_rules();
    t_tdre_sources();
    t_receive();
    t_standby();
    t_set_wins();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule